// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits behind a combined power-good / power-down input of a clock generator. While the board powers up, a set of configuration straps is held at the pins. These are three frequency-select bits, a function-select bit, a debug-clock-select bit and a trusted-mode bit. The straps are taken once, on the first qualified high level of the power-good input, and are then held as static configuration. After that capture, the same input is reused as a live, active-low power-down control.

The latched configuration drives three routing selects for shared output pins. It also drives two controls that apply in test mode. When the test-mode input is high, capture reopens: the configuration follows the straps while power-good is high. The second frequency-select bit then chooses between tri-stating every clock output and driving the reference divided by N. The power-good input is asynchronous and is resynchronised inside the block. The strap and test-mode inputs are assumed to be synchronous to `clk`. All pins are plain control and status levels. The block has no streaming interface.

Top module: `pgood_strap_latch`

## Requirements
- R1: On the clock edge where power-good has been qualified high, `cfg_fs`, `cfg_func`, `cfg_dbg` and `cfg_trusted` take the strap values present at that edge. `strap_done` rises on that same edge.
- R2: Once `strap_done` is high and `test_en` is low, changes on the straps or on `pg_pd_n` leave the configuration outputs unchanged.
- R3: A level on `pg_pd_n` qualifies only after two synchroniser flops and two consecutive high synchronised samples. A high pulse one clock wide is never captured.
- R4: `pd_req` is high only while `strap_done` is high and the synchronised `pg_pd_n` is low. It follows the input with a delay of three clocks, so the low level seen before the first capture never requests power-down.
- R5: Reset (`rst_n` low) clears `strap_done` and `pd_req` and loads the defaults: `cfg_fs`=0, `cfg_func`=0, `cfg_dbg`=0 and `cfg_trusted`=1.
- R6: `pair_a_alt`=1 routes the 27 MHz non-spread/spread clocks to pair A, and 0 routes the 96 MHz dot clock. `pair_b_src`=1 routes serial reference clock 0 to pair B, and 0 routes the 96/100 MHz spread clock. Both selects equal the captured `cfg_func`.
- R7: `dbg_cpu`=1 selects the CPU debug clock on the shared pair, and 0 selects serial reference clock 10. It equals the captured `cfg_dbg`.
- R8: With `test_en` high and power-good qualified, the configuration reloads from the straps on every clock. In that mode, `out_tristate` = NOT `cfg_fs[1]` and `out_refdiv` = `cfg_fs[1]`.
- R9: With `test_en` low, `out_tristate` and `out_refdiv` are both 0.
- R10: `strap_done` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| pg_pd_n | input | 1 | Power-good strobe; after capture, active-low power-down |
| fs_strap | input | 3 | Frequency-select straps |
| func_strap | input | 1 | Function-select strap |
| dbg_strap | input | 1 | Debug-clock-select strap |
| trust_strap | input | 1 | Trusted-mode strap (1 = trusted) |
| test_en | input | 1 | Test-mode enable |
| cfg_fs | output | 3 | Latched frequency select |
| cfg_func | output | 1 | Latched function select |
| cfg_dbg | output | 1 | Latched debug select |
| cfg_trusted | output | 1 | Latched trusted mode |
| strap_done | output | 1 | Capture complete |
| pair_a_alt | output | 1 | Pair A route select |
| pair_b_src | output | 1 | Pair B route select |
| dbg_cpu | output | 1 | Shared debug pair route select |
| pd_req | output | 1 | Power-down request |
| out_tristate | output | 1 | Test mode: tri-state all clock outputs |
| out_refdiv | output | 1 | Test mode: drive reference divided by N |

## Verification
The bench changes straps after capture and toggles power-good again. A design that is not truly one-shot would then show a new configuration. It applies a one-clock power-good glitch; a block without qualification would latch early strap values. It checks that `pd_req` stays low during the pre-capture low period, which a design without gating would flag as power-down. It also enters test mode and checks that capture reopens, and that the tri-state and divide-by-N controls follow the second frequency bit.

// File: rtl/pgsl_pkg.sv
package pgsl_pkg;
  localparam int FS_W = 3;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            func;
    logic            dbg;
    logic            trusted;
  } strap_cfg_t;

  localparam strap_cfg_t CFG_DEFAULT = '{fs: '0, func: 1'b0, dbg: 1'b0, trusted: 1'b1};
endpackage

// File: rtl/pgsl_sync.sv
module pgsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_o,
  output logic qual_o
);
  logic [STAGES-1:0] chain;
  logic              hold_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= chain[STAGES-1];

  assign sync_o = chain[STAGES-1];
  assign qual_o = chain[STAGES-1] & hold_q;
endmodule

// File: rtl/pgsl_capture.sv
module pgsl_capture
  import pgsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_sync,
  input  logic       pg_qual,
  input  logic       test_en,
  input  strap_cfg_t straps,
  output strap_cfg_t cfg_q,
  output logic       done_q,
  output logic       pd_q
);
  logic load;
  assign load = pg_qual & (~done_q | test_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      done_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      if (load) begin
        cfg_q  <= straps;
        done_q <= 1'b1;
      end
      pd_q <= done_q & ~pg_sync;
    end
  end
endmodule

// File: rtl/pgsl_route.sv
module pgsl_route
  import pgsl_pkg::*;
(
  input  strap_cfg_t cfg,
  input  logic       test_en,
  output logic       pair_a_alt,
  output logic       pair_b_src,
  output logic       dbg_cpu,
  output logic       out_tristate,
  output logic       out_refdiv
);
  always_comb begin
    pair_a_alt   = cfg.func;
    pair_b_src   = cfg.func;
    dbg_cpu      = cfg.dbg;
    out_tristate = test_en & ~cfg.fs[1];
    out_refdiv   = test_en &  cfg.fs[1];
  end
endmodule

// File: rtl/pgood_strap_latch.sv
module pgood_strap_latch
  import pgsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_pd_n,
  input  logic [FS_W-1:0] fs_strap,
  input  logic            func_strap,
  input  logic            dbg_strap,
  input  logic            trust_strap,
  input  logic            test_en,
  output logic [FS_W-1:0] cfg_fs,
  output logic            cfg_func,
  output logic            cfg_dbg,
  output logic            cfg_trusted,
  output logic            strap_done,
  output logic            pair_a_alt,
  output logic            pair_b_src,
  output logic            dbg_cpu,
  output logic            pd_req,
  output logic            out_tristate,
  output logic            out_refdiv
);
  logic       pg_sync, pg_qual;
  strap_cfg_t straps, cfg;

  assign straps = '{fs: fs_strap, func: func_strap, dbg: dbg_strap, trusted: trust_strap};

  pgsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pg_pd_n), .sync_o(pg_sync), .qual_o(pg_qual)
  );

  pgsl_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pg_sync(pg_sync), .pg_qual(pg_qual), .test_en(test_en),
    .straps(straps), .cfg_q(cfg), .done_q(strap_done), .pd_q(pd_req)
  );

  pgsl_route u_route (
    .cfg(cfg), .test_en(test_en), .pair_a_alt(pair_a_alt), .pair_b_src(pair_b_src),
    .dbg_cpu(dbg_cpu), .out_tristate(out_tristate), .out_refdiv(out_refdiv)
  );

  assign cfg_fs      = cfg.fs;
  assign cfg_func    = cfg.func;
  assign cfg_dbg     = cfg.dbg;
  assign cfg_trusted = cfg.trusted;
endmodule

// File: rtl/pgood_strap_latch_chk.sv
module pgood_strap_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_en,
  input logic [2:0] fs_strap,
  input logic [2:0] cfg_fs,
  input logic       cfg_func,
  input logic       cfg_dbg,
  input logic       cfg_trusted,
  input logic       strap_done,
  input logic       pd_req,
  input logic       out_tristate,
  input logic       out_refdiv
);
  a_r1_capture_fs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_done) |-> cfg_fs == $past(fs_strap));

  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !test_en) |=> $stable({cfg_fs, cfg_func, cfg_dbg, cfg_trusted}) || test_en);

  a_r4_pd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> strap_done);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> strap_done);

  a_r9_test_off: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> !out_tristate && !out_refdiv);

  a_r8_test_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_tristate && out_refdiv));
endmodule

bind pgood_strap_latch pgood_strap_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .fs_strap(fs_strap),
  .cfg_fs(cfg_fs), .cfg_func(cfg_func), .cfg_dbg(cfg_dbg), .cfg_trusted(cfg_trusted),
  .strap_done(strap_done), .pd_req(pd_req), .out_tristate(out_tristate), .out_refdiv(out_refdiv)
);

// File: tb/test_pgood_strap_latch.sv
module test_pgood_strap_latch;
  logic clk = 1'b0, rst_n = 1'b0, pg = 1'b0;
  logic [2:0] fs = '0;
  logic func = 1'b0, dbg = 1'b0, trust = 1'b1, ten = 1'b0;
  logic [2:0] cfg_fs;
  logic cfg_func, cfg_dbg, cfg_trusted, done, pa, pb, dcpu, pd, tri_o, rdiv;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pgood_strap_latch i_pgood_strap_latch (
    .clk(clk), .rst_n(rst_n), .pg_pd_n(pg), .fs_strap(fs), .func_strap(func),
    .dbg_strap(dbg), .trust_strap(trust), .test_en(ten), .cfg_fs(cfg_fs),
    .cfg_func(cfg_func), .cfg_dbg(cfg_dbg), .cfg_trusted(cfg_trusted),
    .strap_done(done), .pair_a_alt(pa), .pair_b_src(pb), .dbg_cpu(dcpu),
    .pd_req(pd), .out_tristate(tri_o), .out_refdiv(rdiv)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pg = 1'b0; ten = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // R5: reset values
  task automatic t_reset();
    do_reset();
    chk("R5 done", {7'd0, done}, 8'd0);
    chk("R5 cfg", {2'd0, cfg_fs, cfg_func, cfg_dbg, cfg_trusted}, 8'b0000_0001);
    chk("R4 no pd before capture", {7'd0, pd}, 8'd0);
    cyc(6);
    chk("R4 pre-capture low ignored", {7'd0, pd}, 8'd0);
  endtask

  // R3: one-clock glitch is not captured
  task automatic t_glitch();
    fs = 3'b111; func = 1'b1;
    pg = 1'b1; cyc(1); pg = 1'b0;
    cyc(6);
    chk("R3 glitch rejected", {7'd0, done}, 8'd0);
    chk("R3 cfg default", {5'd0, cfg_fs}, 8'd0);
  endtask

  // R1 R6 R7: capture timing and routing
  task automatic t_capture(input logic [2:0] f, input logic fn, input logic d, input logic t);
    fs = f; func = fn; dbg = d; trust = t;
    pg = 1'b1;
    cyc(3);
    chk("R1 not yet captured", {7'd0, done}, 8'd0);
    cyc(1);
    chk("R1 done", {7'd0, done}, 8'd1);
    chk("R1 cfg", {2'd0, cfg_fs, cfg_func, cfg_dbg, cfg_trusted}, {2'd0, f, fn, d, t});
    chk("R6 routes", {6'd0, pa, pb}, {6'd0, fn, fn});
    chk("R7 dbg route", {7'd0, dcpu}, {7'd0, d});
  endtask

  // R2 R4 R10: frozen after capture, pd live
  task automatic t_frozen(input logic [2:0] f, input logic fn, input logic d, input logic t);
    fs = ~f; func = ~fn; dbg = ~d; trust = ~t;
    cyc(3);
    chk("R2 straps ignored", {2'd0, cfg_fs, cfg_func, cfg_dbg, cfg_trusted}, {2'd0, f, fn, d, t});
    pg = 1'b0;
    cyc(2);
    chk("R4 pd delay", {7'd0, pd}, 8'd0);
    cyc(1);
    chk("R4 pd asserted", {7'd0, pd}, 8'd1);
    chk("R10 done holds", {7'd0, done}, 8'd1);
    pg = 1'b1;
    cyc(5);
    chk("R4 pd released", {7'd0, pd}, 8'd0);
    chk("R2 regrant ignored", {2'd0, cfg_fs, cfg_func, cfg_dbg, cfg_trusted}, {2'd0, f, fn, d, t});
    chk("R9 no test ctl", {6'd0, tri_o, rdiv}, 8'd0);
  endtask

  // R8: test mode reopens capture
  task automatic t_test();
    ten = 1'b1; fs = 3'b010; func = 1'b0;
    cyc(2);
    chk("R8 tracks straps", {5'd0, cfg_fs}, 8'd2);
    chk("R8 refdiv", {6'd0, tri_o, rdiv}, 8'b01);
    fs = 3'b101;
    cyc(2);
    chk("R8 tristate", {6'd0, tri_o, rdiv}, 8'b10);
    ten = 1'b0;
    cyc(1);
    chk("R9 test off", {6'd0, tri_o, rdiv}, 8'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_glitch();
        t_capture(3'b101, 1'b0, 1'b1, 1'b0);
        t_frozen(3'b101, 1'b0, 1'b1, 1'b0);
        do_reset();
        chk("R5 reset clears done", {7'd0, done}, 8'd0);
        t_capture(3'b010, 1'b1, 1'b0, 1'b1);
        t_frozen(3'b010, 1'b1, 1'b0, 1'b1);
        t_test();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule